// File: doc/BRIEF.md
# Virtual Channel Input Unit

This block is one input port of a mesh router. It holds several virtual channels, and each one has a small flit queue and a state register. An arriving flit names its virtual channel and carries a two-bit type. The unit writes the flit into that channel's queue.

Each channel moves its packet through four steps: route computation, virtual-channel allocation, switch allocation and switch traversal. Only the head flit does route computation and channel allocation. The head's destination coordinates give the output port, using X-then-Y ordering. The unit raises allocation requests toward outside allocators and records what they grant.

Once a channel is active, every flit of the packet competes for the switch in arrival order. The tail flit frees the channel when it leaves. A following head flit waits behind that tail and starts routing only after the tail has gone.

Top module: `vc_input_unit`

## Requirements
- R1: After reset every channel reads state 0 (idle), no allocation request is raised, `st_valid` is low and `err` is clear.
- R2: A flit with `in_valid` high is stored in the queue picked by `in_vc`, and the flits of one channel leave in the order they arrived. Type codes are 00 body, 01 head, 10 tail and 11 single-flit packet (head and tail together).
- R3: An idle channel whose oldest flit has the head bit (type bit 0) set reads state 1 (routing) one cycle later. It reads state 2 (waiting for a channel) the cycle after that, and `va_req` for it is then high.
- R4: The requested output port in `va_port` is found as follows. The head payload holds the destination X in bits [3:2] and Y in bits [1:0]. If X is larger than the local X, the port is 1; if X is smaller, the port is 2. If X equals the local X, a larger Y gives port 3, a smaller Y gives port 4, and an equal Y gives port 0 (local).
- R5: A channel in state 2 keeps `va_req` high until its bit of `va_gnt` is seen. It then reads state 3 (active) and stores `va_gnt_vc` as its downstream channel.
- R6: `sa_req` for a channel is high only while the channel is active, its queue is not empty and its `sa_credit` bit is set.
- R7: When a channel's `sa_gnt` and `sa_req` are both high, its oldest flit is removed. In the next cycle `st_valid` is high, and `st_data`, `st_type`, `st_port` and `st_vc` show that flit, the stored port and the stored downstream channel.
- R8: When a flit with the tail bit (type bit 1) leaves, its channel reads state 0 in the next cycle.
- R9: A head flit queued behind a tail that has not yet left does not start routing: the channel stays in state 3 until the tail leaves.
- R10: A write to a full queue (4 flits) is dropped and leaves the stored flits unchanged. `err` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_vc | input | 1 | Virtual channel of the incoming flit |
| in_type | input | 2 | Flit type code |
| in_data | input | 8 | Flit payload; destination in head flits |
| va_req | output | 2 | Per-channel request for a downstream channel |
| va_port | output | 6 | Per-channel requested output port, 3 bits each |
| va_gnt | input | 2 | Per-channel downstream-channel grant |
| va_gnt_vc | input | 1 | Granted downstream channel |
| sa_credit | input | 2 | Per-channel: downstream buffer space available |
| sa_req | output | 2 | Per-channel switch request |
| sa_gnt | input | 2 | Per-channel switch grant |
| st_valid | output | 1 | Flit on the switch-traversal outputs |
| st_data | output | 8 | Traversing flit payload |
| st_type | output | 2 | Traversing flit type |
| st_port | output | 3 | Output port of the traversing flit |
| st_vc | output | 1 | Downstream channel of the traversing flit |
| vc_state | output | 4 | Per-channel state, 2 bits each |
| err | output | 1 | Sticky queue-overflow flag |

## Verification
The hardest case to set up is a new head flit that sits in a queue behind a tail still waiting for the switch. To build it, the stimulus sends a whole packet and the next head into one channel. It then holds back the switch grant after the body flit has left, so the tail is left waiting. Over several cycles the bench checks that the channel stays active and does not start routing. It then grants the tail and expects routing to start one cycle after the channel goes idle. Overflow is reached in a similar way: the channel-allocation grant is withheld so nothing drains while a fifth flit is written. Draining the queue afterwards shows that only the first four flits were kept.

// File: rtl/vc_input_unit.sv
module vc_input_unit #(
  parameter int NUM_VC = 2,
  parameter int DEPTH  = 4,
  parameter int DW     = 8,
  parameter int CW     = 2,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1,
  localparam int VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [VCW-1:0]      in_vc,
  input  logic [1:0]          in_type,
  input  logic [DW-1:0]       in_data,
  output logic [NUM_VC-1:0]   va_req,
  output logic [3*NUM_VC-1:0] va_port,
  input  logic [NUM_VC-1:0]   va_gnt,
  input  logic [VCW-1:0]      va_gnt_vc,
  input  logic [NUM_VC-1:0]   sa_credit,
  output logic [NUM_VC-1:0]   sa_req,
  input  logic [NUM_VC-1:0]   sa_gnt,
  output logic                st_valid,
  output logic [DW-1:0]       st_data,
  output logic [1:0]          st_type,
  output logic [2:0]          st_port,
  output logic [VCW-1:0]      st_vc,
  output logic [2*NUM_VC-1:0] vc_state,
  output logic                err
);
  localparam int FW = DW + 2;
  localparam logic [1:0] S_IDLE = 2'd0, S_RC = 2'd1, S_VA = 2'd2, S_ACT = 2'd3;

  logic [FW-1:0]   mem   [NUM_VC][DEPTH];
  logic [PW-1:0]   rdp   [NUM_VC];
  logic [PW-1:0]   wrp   [NUM_VC];
  logic [CNTW-1:0] cnt   [NUM_VC];
  logic [1:0]      st    [NUM_VC];
  logic [2:0]      oport [NUM_VC];
  logic [VCW-1:0]  ovc   [NUM_VC];
  logic [FW-1:0]   front [NUM_VC];
  logic [NUM_VC-1:0] push, pop;
  logic [VCW-1:0]  sel;
  logic            any_pop, overflow;

  function automatic logic [2:0] xy_route(input logic [DW-1:0] d);
    logic [CW-1:0] dx, dy;
    dx = d[2*CW-1:CW];
    dy = d[CW-1:0];
    if (dx > CW'(MY_X))      return 3'd1;
    else if (dx < CW'(MY_X)) return 3'd2;
    else if (dy > CW'(MY_Y)) return 3'd3;
    else if (dy < CW'(MY_Y)) return 3'd4;
    else                     return 3'd0;
  endfunction

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    sel = '0;
    for (int v = NUM_VC - 1; v >= 0; v--) begin
      front[v]          = mem[v][rdp[v]];
      va_req[v]         = (st[v] == S_VA);
      sa_req[v]         = (st[v] == S_ACT) && (cnt[v] != '0) && sa_credit[v];
      va_port[3*v +: 3] = oport[v];
      vc_state[2*v +: 2] = st[v];
      if (sa_gnt[v] && sa_req[v]) sel = VCW'(v);
    end
    any_pop = |(sa_gnt & sa_req);
    pop = '0;
    if (any_pop) pop[sel] = 1'b1;
    overflow = 1'b0;
    for (int v = 0; v < NUM_VC; v++) begin
      push[v] = in_valid && (in_vc == VCW'(v)) &&
                ((cnt[v] != CNTW'(DEPTH)) || pop[v]);
      if (in_valid && (in_vc == VCW'(v)) && (cnt[v] == CNTW'(DEPTH)) && !pop[v])
        overflow = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VC; v++) begin
        rdp[v]   <= '0;
        wrp[v]   <= '0;
        cnt[v]   <= '0;
        st[v]    <= S_IDLE;
        oport[v] <= '0;
        ovc[v]   <= '0;
      end
      st_valid <= 1'b0;
      st_data  <= '0;
      st_type  <= '0;
      st_port  <= '0;
      st_vc    <= '0;
      err      <= 1'b0;
    end else begin
      for (int v = 0; v < NUM_VC; v++) begin
        if (push[v]) begin
          mem[v][wrp[v]] <= {in_type, in_data};
          wrp[v] <= bump(wrp[v]);
        end
        if (pop[v]) rdp[v] <= bump(rdp[v]);
        cnt[v] <= cnt[v] + CNTW'(push[v]) - CNTW'(pop[v]);
        case (st[v])
          S_IDLE: if ((cnt[v] != '0) && front[v][DW]) st[v] <= S_RC;
          S_RC: begin
            oport[v] <= xy_route(front[v][DW-1:0]);
            st[v]    <= S_VA;
          end
          S_VA: if (va_gnt[v]) begin
            ovc[v] <= va_gnt_vc;
            st[v]  <= S_ACT;
          end
          default: if (pop[v] && front[v][DW+1]) st[v] <= S_IDLE;
        endcase
      end
      st_valid <= any_pop;
      if (any_pop) begin
        st_data <= front[sel][DW-1:0];
        st_type <= front[sel][DW+1:DW];
        st_port <= oport[sel];
        st_vc   <= ovc[sel];
      end
      err <= err | overflow;
    end
  end
endmodule

// File: rtl/vc_input_unit_chk.sv
module vc_input_unit_chk #(
  parameter int NUM_VC = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_VC-1:0]   va_req,
  input logic [NUM_VC-1:0]   va_gnt,
  input logic [NUM_VC-1:0]   sa_req,
  input logic [NUM_VC-1:0]   sa_gnt,
  input logic                st_valid,
  input logic [2*NUM_VC-1:0] vc_state,
  input logic                err
);
  a_r7_st_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sa_gnt & sa_req)) |=> st_valid);

  a_r7_st_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(|(sa_gnt & sa_req)));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    a_r3_rc_then_va: assert property (@(posedge clk) disable iff (!rst_n)
      (vc_state[2*v +: 2] == 2'd1) |=> (vc_state[2*v +: 2] == 2'd2));

    a_r5_va_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (va_req[v] && !va_gnt[v]) |=> va_req[v]);

    a_r9_active_until_pop: assert property (@(posedge clk) disable iff (!rst_n)
      ((vc_state[2*v +: 2] == 2'd3) && !(sa_gnt[v] && sa_req[v]))
        |=> (vc_state[2*v +: 2] == 2'd3));
  end
endmodule

bind vc_input_unit vc_input_unit_chk #(.NUM_VC(NUM_VC)) u_chk (
  .clk(clk), .rst_n(rst_n), .va_req(va_req), .va_gnt(va_gnt),
  .sa_req(sa_req), .sa_gnt(sa_gnt), .st_valid(st_valid),
  .vc_state(vc_state), .err(err)
);

// File: tb/sim_vc_input_unit.sv
`timescale 1ns/1ps
module sim_vc_input_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [0:0] in_vc = '0;
  logic [1:0] in_type = '0;
  logic [7:0] in_data = '0;
  logic [1:0] va_req;
  logic [5:0] va_port;
  logic [1:0] va_gnt = '0;
  logic [0:0] va_gnt_vc = '0;
  logic [1:0] sa_credit = '0;
  logic [1:0] sa_req;
  logic [1:0] sa_gnt = '0;
  logic       st_valid;
  logic [7:0] st_data;
  logic [1:0] st_type;
  logic [2:0] st_port;
  logic [0:0] st_vc;
  logic [3:0] vc_state;
  logic       err;
  int n_chk = 0;
  int n_fail = 0;

  // {unused, dest x[1:0], dest y[1:0], expected port[2:0]}; local node is (1,1)
  localparam logic [7:0] VEC [0:6] = '{8'h49, 8'h0A, 8'h33, 8'h24, 8'h28, 8'h61, 8'h1A};

  always #2.5 clk = ~clk;

  vc_input_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
    .in_type(in_type), .in_data(in_data), .va_req(va_req), .va_port(va_port),
    .va_gnt(va_gnt), .va_gnt_vc(va_gnt_vc), .sa_credit(sa_credit),
    .sa_req(sa_req), .sa_gnt(sa_gnt), .st_valid(st_valid), .st_data(st_data),
    .st_type(st_type), .st_port(st_port), .st_vc(st_vc), .vc_state(vc_state),
    .err(err)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sv(input int v);
    return int'(vc_state[2*v +: 2]);
  endfunction

  task automatic put(input int v, input logic [1:0] t, input logic [7:0] d);
    in_valid = 1'b1;
    in_vc    = 1'(v);
    in_type  = t;
    in_data  = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 vc_state", int'(vc_state), 0);
    chk("R1 va_req", int'(va_req), 0);
    chk("R1 sa_req", int'(sa_req), 0);
    chk("R1 st_valid", int'(st_valid), 0);
    chk("R1 err", int'(err), 0);
    sa_credit = 2'b11;

    // table walk: single-flit packets, XY routing
    for (int i = 0; i < 7; i++) begin
      int v;
      int gv;
      logic [7:0] d;
      v  = i % 2;
      gv = (i + 1) % 2;
      d  = {2'(i), VEC[i][6:3], 2'(i)} ;
      d  = {4'(i), VEC[i][6:3]};
      tick(); put(v, 2'b11, d);
      tick(); in_valid = 1'b0;
      chk("R2 stored, idle", sv(v), 0);
      tick();
      chk("R3 routing", sv(v), 1);
      tick();
      chk("R3 vc wait", sv(v), 2);
      chk("R3 va_req", int'(va_req[v]), 1);
      chk("R4 va_port", int'(va_port[3*v +: 3]), int'(VEC[i][2:0]));
      va_gnt[v] = 1'b1; va_gnt_vc = 1'(gv);
      tick(); va_gnt = '0;
      chk("R5 active", sv(v), 3);
      chk("R6 sa_req", int'(sa_req[v]), 1);
      sa_gnt[v] = 1'b1;
      tick(); sa_gnt = '0;
      chk("R7 st_valid", int'(st_valid), 1);
      chk("R7 st_data", int'(st_data), int'(d));
      chk("R7 st_type", int'(st_type), 3);
      chk("R7 st_port", int'(st_port), int'(VEC[i][2:0]));
      chk("R7 st_vc", int'(st_vc), gv);
      chk("R8 idle after tail", sv(v), 0);
    end

    // multi-flit packet on channel 1 with a head queued behind the tail
    tick();
    sa_credit = 2'b00;
    put(1, 2'b01, 8'h09);          // head to (2,1) -> port 1
    tick(); put(1, 2'b00, 8'hB1);
    tick(); put(1, 2'b10, 8'hC2);
    tick(); put(1, 2'b11, 8'h06);  // next packet head to (1,2) -> port 3
    chk("R5 waits for grant", sv(1), 2);
    tick(); in_valid = 1'b0;
    chk("R5 va_req held", int'(va_req[1]), 1);
    chk("R5 still waiting", sv(1), 2);
    va_gnt[1] = 1'b1; va_gnt_vc = 1'b0;
    tick(); va_gnt = '0;
    chk("R5 active", sv(1), 3);
    chk("R6 no credit no request", int'(sa_req[1]), 0);
    sa_credit = 2'b11;
    tick();
    chk("R6 credit gives request", int'(sa_req[1]), 1);
    sa_gnt[1] = 1'b1;
    tick();
    chk("R7 head leaves", int'(st_valid), 1);
    chk("R2 order head", int'(st_data), 8'h09);
    chk("R7 port east", int'(st_port), 1);
    tick(); sa_gnt = '0;
    chk("R2 order body", int'(st_data), 8'hB1);
    chk("R9 active while tail waits", sv(1), 3);
    tick();
    chk("R9 no routing behind tail", sv(1), 3);
    chk("R7 no grant no traversal", int'(st_valid), 0);
    tick();
    chk("R9 still held", sv(1), 3);
    sa_gnt[1] = 1'b1;
    tick(); sa_gnt = '0;
    chk("R2 order tail", int'(st_data), 8'hC2);
    chk("R8 tail frees channel", sv(1), 0);
    tick();
    chk("R9 routing resumes", sv(1), 1);
    tick();
    chk("R4 north port", int'(va_port[5:3]), 3);
    va_gnt[1] = 1'b1; va_gnt_vc = 1'b1;
    tick(); va_gnt = '0; sa_gnt[1] = 1'b1;
    tick(); sa_gnt = '0;
    chk("R7 second packet", int'(st_data), 8'h06);
    chk("R7 second vc", int'(st_vc), 1);
    chk("R8 idle again", sv(1), 0);

    // overflow on channel 0
    tick();
    put(0, 2'b01, 8'h01);          // head to (0,1) -> port 2
    tick(); put(0, 2'b00, 8'hD1);
    tick(); put(0, 2'b00, 8'hD2);
    tick(); put(0, 2'b00, 8'hD3);
    tick(); put(0, 2'b00, 8'hEE);  // fifth write, queue full
    tick(); in_valid = 1'b0;
    chk("R10 err set", int'(err), 1);
    va_gnt[0] = 1'b1; va_gnt_vc = 1'b1;
    tick(); va_gnt = '0; sa_gnt[0] = 1'b1;
    tick();
    chk("R10 kept 1", int'(st_data), 8'h01);
    tick();
    chk("R10 kept 2", int'(st_data), 8'hD1);
    tick();
    chk("R10 kept 3", int'(st_data), 8'hD2);
    tick();
    chk("R10 kept 4", int'(st_data), 8'hD3);
    tick();
    chk("R10 fifth dropped", int'(st_valid), 0);
    chk("R6 empty queue no request", int'(sa_req[0]), 0);
    chk("R10 err sticky", int'(err), 1);
    sa_gnt = '0;
    put(0, 2'b10, 8'hF0);
    tick(); in_valid = 1'b0;
    sa_gnt[0] = 1'b1;
    tick(); sa_gnt = '0;
    chk("R8 tail after drain", int'(st_data), 8'hF0);
    chk("R8 idle after drain", sv(0), 0);

    do_reset();
    chk("R1 err cleared", int'(err), 0);
    chk("R1 states idle", int'(vc_state), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule